// File: doc/BRIEF.md
# Parallel Video Crop Window

This block sits on a parallel camera input, between the sensor pins and a capture or DMA stage. It counts bus samples along each line and completed lines within each frame. It forwards only the samples that fall inside a programmed rectangle. A sensor that sends longer lines or more lines than the capture side expects can then never push more data downstream than the buffer was sized for.

A write-only configuration port holds an inclusive column range, an inclusive row range and one enable per axis. All limits count data-bus samples, not pixels. A format that spreads one pixel over two bus beats therefore needs its limits doubled by software. New settings are staged and only reach the comparators at the next frame start.

Top module: `vcw_crop_top`

## Requirements
- R1: While reset is asserted and after it is released, crop_valid, crop_sof and crop_eol are low, and both axis enables are off.
- R2: With both enables off, every sample presented with pix_en=1 and line_sync=1 is forwarded unchanged, one clock later. There is no limit on line length or line count, so a frame ends only through the sync inputs.
- R3: Register map (byte offsets on cfg_addr): 0x00 control, where bit 12 enables column limiting and bit 13 enables row limiting; 0x10 column window, with min in bits 15:0 and max in bits 31:16; 0x14 row window, with the same field layout. Writes to other offsets and to the other control bits have no effect.
- R4: The column index is the 0-based count of accepted samples (pix_en=1 while line_sync=1) since line_sync last went high. Cycles with pix_en=0 do not advance it. With column limiting on, a sample is forwarded only if min <= column <= max, where both bounds are inclusive.
- R5: The row index is the number of line_sync falling edges since the last frame start. With row limiting on, a sample is forwarded only if min <= row <= max, where both bounds are inclusive.
- R6: The two enables act independently. When both are on, a sample must pass both checks to be forwarded.
- R7: Both indices saturate at 0xFFFF rather than wrapping, so a line or frame longer than 65536 samples or lines never re-enters the window.
- R8: crop_data, crop_valid and crop_sof follow the accepted sample by exactly one clock. crop_sof is high only on the first forwarded sample after a frame start.
- R9: With column limiting on, crop_eol is high on the forwarded sample whose column equals the column max. With column limiting off, crop_eol stays low.
- R10: A frame start is a rising edge of frame_sync, and it takes effect for samples on the following cycles. Configuration writes are staged, and the window in use changes only at a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| pix_en | input | 1 | Sample qualifier from the sensor |
| line_sync | input | 1 | High while a line is active |
| frame_sync | input | 1 | Rising edge marks a frame start |
| pix_data | input | DATA_W | Sample data bus |
| crop_valid | output | 1 | Forwarded sample strobe |
| crop_data | output | DATA_W | Forwarded sample |
| crop_sof | output | 1 | First forwarded sample of the frame |
| crop_eol | output | 1 | Sample at the column maximum |

## Verification
Every output result is due on the first rising edge after the sample is presented. The bench drives inputs on falling edges and compares the outputs on the next falling edge, against an arithmetic model that it advanced when it drove that sample. A configuration write becomes visible only to samples that follow the next frame_sync rising edge, counted one cycle after that edge, and the model stages writes in the same way. Frame-level counts of forwarded samples, start markers and line-end markers are checked against closed-form products of the clipped window sizes.

// File: rtl/vcw_pkg.sv
package vcw_pkg;
  localparam int LIM_W     = 16;
  localparam int REG_W     = 32;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_COLW  = 'h10;
  localparam int OFS_ROWW  = 'h14;
  localparam int BIT_COLEN = 12;
  localparam int BIT_ROWEN = 13;
  localparam int N_AXIS    = 2;

  typedef struct packed {
    logic [LIM_W-1:0] hi;
    logic [LIM_W-1:0] lo;
  } win_t;

  typedef struct packed {
    logic col_en;
    logic row_en;
    win_t col;
    win_t row;
  } crop_cfg_t;

  function automatic logic [LIM_W-1:0] sat_inc(input logic [LIM_W-1:0] v);
    return (v == {LIM_W{1'b1}}) ? v : v + LIM_W'(1);
  endfunction
endpackage

// File: rtl/vcw_cfg_regs.sv
module vcw_cfg_regs
  import vcw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              frame_start,
  output crop_cfg_t         act
);
  crop_cfg_t pend_q, pend_d, act_d;
  logic      unused_bits;

  assign unused_bits = ^{wdata[BIT_COLEN-1:0], wdata[REG_W-1:BIT_ROWEN+1]};

  always_comb begin
    pend_d = pend_q;
    if (wr) begin
      if (addr == ADDR_W'(OFS_CTRL)) begin
        pend_d.col_en = wdata[BIT_COLEN];
        pend_d.row_en = wdata[BIT_ROWEN];
      end else if (addr == ADDR_W'(OFS_COLW)) begin
        pend_d.col = wdata;
      end else if (addr == ADDR_W'(OFS_ROWW)) begin
        pend_d.row = wdata;
      end
    end
    act_d = frame_start ? pend_q : act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act    <= '0;
    end else begin
      pend_q <= pend_d;
      act    <= act_d;
    end
  end

  // R10: the active window moves only at a frame start
  a_r10_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act));
endmodule

// File: rtl/vcw_counters.sv
module vcw_counters
  import vcw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             line_act,
  input  logic             fsync,
  output logic [LIM_W-1:0] col,
  output logic [LIM_W-1:0] row,
  output logic             frame_start
);
  logic             hs_q, vs_q, line_end;
  logic [LIM_W-1:0] col_d, row_d;

  always_comb begin
    frame_start = fsync & ~vs_q;
    line_end    = hs_q & ~line_act;
    if (!line_act)   col_d = '0;
    else if (smp_en) col_d = sat_inc(col);
    else             col_d = col;
    if (frame_start)   row_d = '0;
    else if (line_end) row_d = sat_inc(row);
    else               row_d = row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      col  <= '0;
      row  <= '0;
    end else begin
      hs_q <= line_act;
      vs_q <= fsync;
      col  <= col_d;
      row  <= row_d;
    end
  end

  // R7: saturated counters stay put
  a_r7_col_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (line_act && col == {LIM_W{1'b1}}) |=> col == {LIM_W{1'b1}});
  a_r7_row_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && row == {LIM_W{1'b1}}) |=> row == {LIM_W{1'b1}});
  // R5: frame start clears the row index
  a_r5_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> row == '0);
endmodule

// File: rtl/vcw_axis_check.sv
module vcw_axis_check
  import vcw_pkg::*;
(
  input  logic             en,
  input  logic [LIM_W-1:0] idx,
  input  win_t             win,
  output logic             ok,
  output logic             at_hi
);
  always_comb begin
    ok    = !en || ((idx >= win.lo) && (idx <= win.hi));
    at_hi = en && (idx == win.hi);
  end
endmodule

// File: rtl/vcw_out_stage.sv
module vcw_out_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              col_ok,
  input  logic              row_ok,
  input  logic              col_last,
  input  logic              frame_start,
  input  logic [DATA_W-1:0] din,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_data,
  output logic              o_sof,
  output logic              o_eol
);
  logic fwd, sof_pend, sof_pend_d;

  always_comb begin
    fwd = take & col_ok & row_ok;
    if (frame_start) sof_pend_d = 1'b1;
    else if (fwd)    sof_pend_d = 1'b0;
    else             sof_pend_d = sof_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_pend <= 1'b0;
      o_valid  <= 1'b0;
      o_sof    <= 1'b0;
      o_eol    <= 1'b0;
      o_data   <= '0;
    end else begin
      sof_pend <= sof_pend_d;
      o_valid  <= fwd;
      o_sof    <= fwd & sof_pend;
      o_eol    <= fwd & col_last;
      if (fwd) o_data <= din;
    end
  end

  // R8: one-clock latency from an accepted sample
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(take));
  a_r8_sof_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    o_sof |-> o_valid);
  // R9: line-end marker rides on a forwarded sample
  a_r9_eol_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    o_eol |-> o_valid);
endmodule

// File: rtl/vcw_crop_top.sv
module vcw_crop_top
  import vcw_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              pix_en,
  input  logic              line_sync,
  input  logic              frame_sync,
  input  logic [DATA_W-1:0] pix_data,
  output logic              crop_valid,
  output logic [DATA_W-1:0] crop_data,
  output logic              crop_sof,
  output logic              crop_eol
);
  crop_cfg_t        act;
  logic [LIM_W-1:0] col, row;
  logic             frame_start, take;
  logic [N_AXIS-1:0] ax_en, ax_ok, ax_hi;
  logic [LIM_W-1:0] ax_idx [N_AXIS];
  win_t             ax_win [N_AXIS];
  logic             unused_row_hi;

  assign take = pix_en & line_sync;

  vcw_cfg_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .frame_start(frame_start), .act(act));

  vcw_counters cnt_i (
    .clk(clk), .rst_n(rst_n), .smp_en(pix_en), .line_act(line_sync),
    .fsync(frame_sync), .col(col), .row(row), .frame_start(frame_start));

  assign ax_en[0]  = act.col_en;
  assign ax_idx[0] = col;
  assign ax_win[0] = act.col;
  assign ax_en[1]  = act.row_en;
  assign ax_idx[1] = row;
  assign ax_win[1] = act.row;

  for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
    vcw_axis_check chk_i (
      .en(ax_en[g]), .idx(ax_idx[g]), .win(ax_win[g]),
      .ok(ax_ok[g]), .at_hi(ax_hi[g]));
  end

  assign unused_row_hi = ax_hi[1];

  vcw_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .take(take), .col_ok(ax_ok[0]),
    .row_ok(ax_ok[1]), .col_last(ax_hi[0]), .frame_start(frame_start),
    .din(pix_data), .o_valid(crop_valid), .o_data(crop_data),
    .o_sof(crop_sof), .o_eol(crop_eol));
endmodule

// File: tb/vcw_crop_top_tb.sv
module vcw_crop_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [7:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic pix_en, line_sync, frame_sync;
  logic [DW-1:0] pix_data;
  logic crop_valid, crop_sof, crop_eol;
  logic [DW-1:0] crop_data;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_col, m_row, m_hsq, m_vsq, m_sofp;
  int p_cen, p_ren, p_cmin, p_cmax, p_rmin, p_rmax;
  int a_cen, a_ren, a_cmin, a_cmax, a_rmin, a_rmax;
  int e_v, e_sof, e_eol;
  logic [DW-1:0] e_d;
  int fwd_cnt, sof_cnt, eol_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcw_crop_top #(.DATA_W(DW), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_en(pix_en), .line_sync(line_sync),
    .frame_sync(frame_sync), .pix_data(pix_data), .crop_valid(crop_valid),
    .crop_data(crop_data), .crop_sof(crop_sof), .crop_eol(crop_eol));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= 65535) ? 65535 : v + 1;
  endfunction

  task automatic check_out();
    chk({cur_req, " valid"}, int'(crop_valid), e_v);
    chk({cur_req, " R8 sof"}, int'(crop_sof), e_sof);
    chk({cur_req, " R9 eol"}, int'(crop_eol), e_eol);
    if (e_v != 0) chk({cur_req, " R2 data"}, int'(crop_data), int'(e_d));
    if (crop_valid) fwd_cnt++;
    if (crop_sof) sof_cnt++;
    if (crop_eol) eol_cnt++;
  endtask

  task automatic drive(input int v, input int hs, input int vs,
                       input logic [DW-1:0] d, input int wr,
                       input logic [7:0] a, input logic [31:0] wd);
    int fwd;
    @(negedge clk);
    check_out();
    pix_en = v[0]; line_sync = hs[0]; frame_sync = vs[0]; pix_data = d;
    cfg_wr = wr[0]; cfg_addr = a; cfg_wdata = wd;
    fwd = (v != 0 && hs != 0 &&
           (a_cen == 0 || (m_col >= a_cmin && m_col <= a_cmax)) &&
           (a_ren == 0 || (m_row >= a_rmin && m_row <= a_rmax))) ? 1 : 0;
    e_v = fwd;
    e_d = d;
    e_sof = (fwd != 0 && m_sofp != 0) ? 1 : 0;
    e_eol = (fwd != 0 && a_cen != 0 && m_col == a_cmax) ? 1 : 0;
    if (wr != 0) begin
      if (a == 8'h00) begin p_cen = int'(wd[12]); p_ren = int'(wd[13]); end
      else if (a == 8'h10) begin p_cmin = int'(wd[15:0]); p_cmax = int'(wd[31:16]); end
      else if (a == 8'h14) begin p_rmin = int'(wd[15:0]); p_rmax = int'(wd[31:16]); end
    end
    if (vs != 0 && m_vsq == 0) begin
      m_row = 0; m_sofp = 1;
      a_cen = p_cen; a_ren = p_ren; a_cmin = p_cmin; a_cmax = p_cmax;
      a_rmin = p_rmin; a_rmax = p_rmax;
    end else begin
      if (m_hsq != 0 && hs == 0) m_row = sat(m_row);
      if (fwd != 0) m_sofp = 0;
    end
    if (hs == 0) m_col = 0;
    else if (v != 0) m_col = sat(m_col);
    m_hsq = hs; m_vsq = vs;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] wd);
    drive(0, 0, 0, '0, 1, a, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, '0, 0, 8'h00, '0);
  endtask

  // wl >= 0: stage a write in the gap after line wl
  task automatic run_frame(input int h, input int w, input int gap, input int wl,
                           input logic [7:0] wa, input logic [31:0] wd);
    fwd_cnt = 0; sof_cnt = 0; eol_cnt = 0;
    drive(0, 0, 1, '0, 0, 8'h00, '0);
    drive(0, 0, 0, '0, 0, 8'h00, '0);
    for (int l = 0; l < h; l++) begin
      for (int s = 0; s < w; s++) begin
        if (gap != 0 && (s % 3) == 2) drive(0, 1, 0, DW'(12'hFFF), 0, 8'h00, '0);
        drive(1, 1, 0, DW'(l * 37 + s * 5 + 1), 0, 8'h00, '0);
      end
      if (l == wl) drive(0, 0, 0, '0, 1, wa, wd);
      else drive(0, 0, 0, '0, 0, 8'h00, '0);
      drive(0, 0, 0, '0, 0, 8'h00, '0);
    end
    idle(1);
  endtask

  function automatic int in_win(input int lo, input int hi, input int n);
    int top;
    top = (hi < n - 1) ? hi : n - 1;
    return (lo > top) ? 0 : top - lo + 1;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 190000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int exp_n;
    m_col = 0; m_row = 0; m_hsq = 0; m_vsq = 0; m_sofp = 0;
    p_cen = 0; p_ren = 0; p_cmin = 0; p_cmax = 0; p_rmin = 0; p_rmax = 0;
    a_cen = 0; a_ren = 0; a_cmin = 0; a_cmax = 0; a_rmin = 0; a_rmax = 0;
    e_v = 0; e_sof = 0; e_eol = 0; e_d = '0;
    rst_n = 1'b0; cfg_wr = 0; cfg_addr = '0; cfg_wdata = '0;
    pix_en = 0; line_sync = 0; frame_sync = 0; pix_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 reset valid", int'(crop_valid), 0);
    chk("R1 reset sof", int'(crop_sof), 0);
    chk("R1 reset eol", int'(crop_eol), 0);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(2);

    // R2: pass-through, long and gappy frame
    cur_req = "R2";
    run_frame(3, 70, 1, -1, 8'h00, '0);
    chk("R2 count", fwd_cnt, 210);
    chk("R1/R9 no eol when column off", eol_cnt, 0);

    // R3/R4: column window 2..4, plus writes that must be ignored
    cur_req = "R4";
    wreg(8'h10, {16'd4, 16'd2});
    wreg(8'h14, {16'd1, 16'd1});
    wreg(8'h00, 32'h0000_1000);
    wreg(8'h04, 32'h0000_0000);
    wreg(8'h18, 32'h0001_0001);
    run_frame(4, 8, 1, -1, 8'h00, '0);
    chk("R3/R4 column only count", fwd_cnt, 12);
    chk("R9 eol per line", eol_cnt, 4);
    chk("R8 one sof", sof_cnt, 1);
    wreg(8'h00, 32'hFFFF_CFFF);
    run_frame(2, 5, 0, -1, 8'h00, '0);
    chk("R3 other control bits ignored", fwd_cnt, 10);

    // R5/R6: row only, then both
    cur_req = "R5";
    wreg(8'h14, {16'd2, 16'd1});
    wreg(8'h00, 32'h0000_2000);
    run_frame(4, 8, 0, -1, 8'h00, '0);
    chk("R5/R6 row only count", fwd_cnt, 16);
    cur_req = "R6";
    wreg(8'h00, 32'h0000_3000);
    run_frame(4, 8, 0, -1, 8'h00, '0);
    chk("R6 both count", fwd_cnt, 6);

    // R10: a mid-frame write must wait for the next frame start
    cur_req = "R10";
    run_frame(4, 8, 0, 0, 8'h10, {16'd7, 16'd0});
    chk("R10 old window kept mid-frame", fwd_cnt, 6);
    run_frame(4, 8, 0, -1, 8'h00, '0);
    chk("R10 new window next frame", fwd_cnt, 16);

    // near-exhaustive sweep of small windows
    cur_req = "R4/R5 sweep";
    for (int cmin = 0; cmin < 6; cmin++)
      for (int cmax = 0; cmax < 7; cmax++)
        for (int rmin = 0; rmin < 3; rmin++)
          for (int rmax = 0; rmax < 5; rmax++) begin
            wreg(8'h10, {16'(cmax), 16'(cmin)});
            wreg(8'h14, {16'(rmax), 16'(rmin)});
            wreg(8'h00, 32'h0000_3000);
            run_frame(4, 6, cmin % 2, -1, 8'h00, '0);
            exp_n = in_win(cmin, cmax, 6) * in_win(rmin, rmax, 4);
            chk("R4/R5/R6 sweep count", fwd_cnt, exp_n);
            chk("R8 sweep sof", sof_cnt, (exp_n > 0) ? 1 : 0);
            chk("R9 sweep eol", eol_cnt,
                (cmax < 6 && cmax >= cmin) ? in_win(rmin, rmax, 4) : 0);
          end

    // R7: a 65540-sample line must not wrap back into window 0..3
    cur_req = "R7";
    wreg(8'h10, {16'd3, 16'd0});
    wreg(8'h00, 32'h0000_1000);
    fwd_cnt = 0;
    drive(0, 0, 1, '0, 0, 8'h00, '0);
    drive(0, 0, 0, '0, 0, 8'h00, '0);
    for (int s = 0; s < 65540; s++) drive(1, 1, 0, DW'(s), 0, 8'h00, '0);
    idle(2);
    chk("R7 saturated column count", fwd_cnt, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule